// File: doc/BRIEF.md
# Packed Media Integer ALU

This block is a single-stage 64-bit SIMD integer unit for media kernels. Each request carries a 4-bit operation code and two 64-bit operands, `in_a` and `in_b`. The operands are treated as eight unsigned byte lanes or four word lanes, depending on the operation. The unit can:

- take the rounded unsigned average of bytes or of words;
- keep the upper half of each unsigned word product;
- take the signed-word or unsigned-byte maximum or minimum;
- sum the absolute byte differences into one scalar;
- gather the top bit of each byte of `in_a` into a small mask.

The result is registered. `out_valid` rises in the cycle after a valid request.

A two-state output controller tracks whether the result register holds a fresh answer. The states are `ST_IDLE` (no new result this cycle) and `ST_HOLD` (a result was captured at the last edge). There are two transitions:

- `GO_HOLD` is taken on any edge where `in_valid` is high, whatever the current state.
- `GO_IDLE` is taken on any edge where `in_valid` is low.

Reset forces `ST_IDLE`. The result register loads only on edges where `in_valid` is high, and keeps its value otherwise.

Top module: `media_alu_top`

## Requirements
- R1: While `rst_n` is low and after reset is released, `out_valid`, `out_illegal` and `out_result` are all zero until the first valid request.
- R2: `out_valid` is high in the cycle after an edge with `in_valid` high, and low in the cycle after an edge with `in_valid` low.
- R3: On an edge with `in_valid` low, `out_result` keeps its value, whatever `in_op`, `in_a` and `in_b` carry.
- R4: Op 0 gives, for each byte lane, (a+b+1)>>1 computed 9 bits wide. For example, FFh with FFh gives FFh.
- R5: Op 1 gives, for each 16-bit lane, (a+b+1)>>1 computed 17 bits wide.
- R6: Op 2 gives, for each 16-bit lane, bits [31:16] of the unsigned 32-bit product a*b.
- R7: Op 3 gives the signed maximum and op 4 the signed minimum of each 16-bit lane pair.
- R8: Op 5 gives the unsigned maximum and op 6 the unsigned minimum of each byte lane pair.
- R9: Op 7 places the sum over the eight byte lanes of |a-b| in bits [15:0] and clears bits [63:16]. The largest possible sum is 2040.
- R10: Op 8 sets result bit i to bit 7 of byte lane i of `in_a`, for i = 0 to 7, and clears bits [63:8].
- R11: Op codes 9 to 15 give a zero result, and `out_illegal` is high only in the cycle that result is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe, one operation per cycle |
| in_op | input | 4 | Operation code (0 to 8 defined) |
| in_a | input | 64 | First packed operand |
| in_b | input | 64 | Second packed operand |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 64 | Registered packed or scalar result |
| out_illegal | output | 1 | Undefined op code in the presented request |

## Verification
The assertions assume that `in_valid` is a clean 0 or 1 while reset is low, and that no request is made in the reset cycles. The bench holds `in_valid` low through reset and for one cycle after it. The SAD bound check assumes lanes are exactly eight bits wide, which the default parameters fix. The random stimulus draws op codes across all sixteen values, so undefined codes are also exercised. Between requests it drives random garbage with `in_valid` low, so the hold rule is tested under changing inputs.

// File: rtl/media_alu_pkg.sv
package media_alu_pkg;
    localparam int unsigned DATA_W = 64;
    localparam int unsigned OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_AVG_B  = 4'd0,
        OP_AVG_W  = 4'd1,
        OP_MULH_W = 4'd2,
        OP_MAX_SW = 4'd3,
        OP_MIN_SW = 4'd4,
        OP_MAX_UB = 4'd5,
        OP_MIN_UB = 4'd6,
        OP_SAD_B  = 4'd7,
        OP_MSK_B  = 4'd8
    } media_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } out_state_e;
endpackage

// File: rtl/media_avg.sv
module media_avg #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned LANE_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    localparam int unsigned LANES = DATA_W / LANE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W:0] wide;
        always_comb begin
            wide = {1'b0, a[g*LANE_W +: LANE_W]} + {1'b0, b[g*LANE_W +: LANE_W]}
                   + {{LANE_W{1'b0}}, 1'b1};
            y[g*LANE_W +: LANE_W] = wide[LANE_W:1];
        end
    end
endmodule

// File: rtl/media_minmax.sv
module media_minmax #(
    parameter int unsigned DATA_W    = 64,
    parameter int unsigned LANE_W    = 16,
    parameter bit          IS_SIGNED = 1'b1
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y_max,
    output logic [DATA_W-1:0] y_min
);
    localparam int unsigned LANES = DATA_W / LANE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] la, lb;
        logic              a_gt;
        always_comb begin
            la = a[g*LANE_W +: LANE_W];
            lb = b[g*LANE_W +: LANE_W];
            if (IS_SIGNED) a_gt = $signed(la) > $signed(lb);
            else           a_gt = la > lb;
            y_max[g*LANE_W +: LANE_W] = a_gt ? la : lb;
            y_min[g*LANE_W +: LANE_W] = a_gt ? lb : la;
        end
    end
endmodule

// File: rtl/media_sad.sv
module media_sad #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned LANE_W = 8,
    parameter int unsigned OUT_W  = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [OUT_W-1:0]  sum
);
    localparam int unsigned LANES   = DATA_W / LANE_W;
    localparam int unsigned MAX_SUM = LANES * ((1 << LANE_W) - 1);
    localparam int unsigned ACC_W   = $clog2(MAX_SUM + 1);

    logic [ACC_W-1:0] acc;

    always_comb begin
        acc = '0;
        for (int i = 0; i < LANES; i++) begin
            logic [LANE_W-1:0] x, z;
            x = a[i*LANE_W +: LANE_W];
            z = b[i*LANE_W +: LANE_W];
            acc = acc + ACC_W'((x > z) ? (x - z) : (z - x));
        end
        sum = OUT_W'(acc);
    end

    // R9: accumulated sum never exceeds eight times the lane maximum
    always_comb begin
        assert_sad_bound_R9: assert (32'(acc) <= MAX_SUM)
            else $error("sad sum %0d above bound", acc);
    end
endmodule

// File: rtl/media_alu_top.sv
module media_alu_top
    import media_alu_pkg::*;
#(
    parameter int unsigned W      = DATA_W,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned WORD_W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [3:0]    in_op,
    input  logic [W-1:0]  in_a,
    input  logic [W-1:0]  in_b,
    output logic          out_valid,
    output logic [W-1:0]  out_result,
    output logic          out_illegal
);
    localparam int unsigned N_BYTES = W / BYTE_W;
    localparam int unsigned N_WORDS = W / WORD_W;

    out_state_e state_q, state_d;
    logic [W-1:0] avg_b, avg_w, max_sw, min_sw, max_ub, min_ub, mulh;
    logic [WORD_W-1:0] sad_sum;
    logic [W-1:0] res_d;
    logic         ill_d, ill_q;

    media_avg #(.DATA_W(W), .LANE_W(BYTE_W)) u_avg_b (.a(in_a), .b(in_b), .y(avg_b));
    media_avg #(.DATA_W(W), .LANE_W(WORD_W)) u_avg_w (.a(in_a), .b(in_b), .y(avg_w));
    media_minmax #(.DATA_W(W), .LANE_W(WORD_W), .IS_SIGNED(1'b1)) u_mm_w (
        .a(in_a), .b(in_b), .y_max(max_sw), .y_min(min_sw));
    media_minmax #(.DATA_W(W), .LANE_W(BYTE_W), .IS_SIGNED(1'b0)) u_mm_b (
        .a(in_a), .b(in_b), .y_max(max_ub), .y_min(min_ub));
    media_sad #(.DATA_W(W), .LANE_W(BYTE_W), .OUT_W(WORD_W)) u_sad (
        .a(in_a), .b(in_b), .sum(sad_sum));

    for (genvar g = 0; g < N_WORDS; g++) begin : g_mulh
        logic [2*WORD_W-1:0] prod;
        always_comb begin
            prod = {{WORD_W{1'b0}}, in_a[g*WORD_W +: WORD_W]}
                 * {{WORD_W{1'b0}}, in_b[g*WORD_W +: WORD_W]};
            mulh[g*WORD_W +: WORD_W] = prod[2*WORD_W-1:WORD_W];
        end
    end

    // operation select
    always_comb begin
        res_d = '0;
        ill_d = 1'b0;
        unique case (in_op)
            OP_AVG_B:  res_d = avg_b;
            OP_AVG_W:  res_d = avg_w;
            OP_MULH_W: res_d = mulh;
            OP_MAX_SW: res_d = max_sw;
            OP_MIN_SW: res_d = min_sw;
            OP_MAX_UB: res_d = max_ub;
            OP_MIN_UB: res_d = min_ub;
            OP_SAD_B:  res_d = {{(W-WORD_W){1'b0}}, sad_sum};
            OP_MSK_B: begin
                for (int i = 0; i < N_BYTES; i++)
                    res_d[i] = in_a[i*BYTE_W + BYTE_W - 1];
            end
            default:   ill_d = 1'b1;
        endcase
    end

    // next state
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_HOLD : ST_IDLE;
            ST_HOLD: state_d = in_valid ? ST_HOLD : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_result <= '0;
            ill_q      <= 1'b0;
        end else if (in_valid) begin
            out_result <= res_d;
            ill_q      <= ill_d;
        end
    end

    // outputs
    always_comb begin
        out_valid   = (state_q == ST_HOLD);
        out_illegal = out_valid & ill_q;
    end

    assert_valid_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result));
    assert_mask_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 4'd8) |=> (out_result[W-1:N_BYTES] == '0));
    assert_sad_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 4'd7) |=> (out_result[W-1:WORD_W] == '0));
    assert_illegal_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_valid && out_result == '0));
    assert_illegal_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_illegal);
endmodule

// File: tb/sim_media_alu_top.sv
module sim_media_alu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_op = '0;
    logic [63:0] in_a = '0, in_b = '0;
    logic        out_valid, out_illegal;
    logic [63:0] out_result;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    media_alu_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
        .out_result(out_result), .out_illegal(out_illegal));

    function automatic logic [63:0] model(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] r = '0;
        int acc = 0;
        case (op)
            4'd0: for (int i = 0; i < 8; i++) r[8*i +: 8] = 8'((int'(a[8*i +: 8]) + int'(b[8*i +: 8]) + 1) / 2);
            4'd1: for (int i = 0; i < 4; i++) r[16*i +: 16] = 16'((int'(a[16*i +: 16]) + int'(b[16*i +: 16]) + 1) / 2);
            4'd2: for (int i = 0; i < 4; i++) begin
                      longint p = longint'(a[16*i +: 16]) * longint'(b[16*i +: 16]);
                      r[16*i +: 16] = 16'(p >> 16);
                  end
            4'd3, 4'd4: for (int i = 0; i < 4; i++) begin
                      int sa = int'($signed(a[16*i +: 16]));
                      int sb = int'($signed(b[16*i +: 16]));
                      int pick = (op == 4'd3) ? ((sa > sb) ? sa : sb) : ((sa < sb) ? sa : sb);
                      r[16*i +: 16] = 16'(pick);
                  end
            4'd5, 4'd6: for (int i = 0; i < 8; i++) begin
                      int ua = int'(a[8*i +: 8]);
                      int ub = int'(b[8*i +: 8]);
                      int pick = (op == 4'd5) ? ((ua > ub) ? ua : ub) : ((ua < ub) ? ua : ub);
                      r[8*i +: 8] = 8'(pick);
                  end
            4'd7: begin
                      for (int i = 0; i < 8; i++) begin
                          int d = int'(a[8*i +: 8]) - int'(b[8*i +: 8]);
                          acc += (d < 0) ? -d : d;
                      end
                      r = 64'(acc);
                  end
            4'd8: for (int i = 0; i < 8; i++) r[i] = a[8*i + 7];
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0: return "R4";  4'd1: return "R5";  4'd2: return "R6";
            4'd3, 4'd4: return "R7";  4'd5, 4'd6: return "R8";
            4'd7: return "R9";  4'd8: return "R10";
            default: return "R11";
        endcase
    endfunction

    // one request, then one idle cycle with garbage inputs
    task automatic run_op(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] exp = model(op, a, b);
        logic        exp_ill = (op > 4'd8);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
        @(negedge clk);
        check(out_valid === 1'b1, "R2", 64'(out_valid), 64'd1);
        check(out_result === exp, req_of(op), out_result, exp);
        check(out_illegal === exp_ill, "R11", 64'(out_illegal), 64'(exp_ill));
        in_valid = 1'b0;
        in_op = 4'($urandom); in_a = {$urandom, $urandom}; in_b = {$urandom, $urandom};
        @(negedge clk);
        check(out_valid === 1'b0, "R2", 64'(out_valid), 64'd0);
        check(out_result === exp, "R3", out_result, exp);
        check(out_illegal === 1'b0, "R11", 64'(out_illegal), 64'd0);
    endtask

    initial begin
        #(5.0 * 20000);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0 && out_illegal === 1'b0 && out_result === '0, "R1",
              {62'd0, out_valid, out_illegal} | out_result, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0 && out_result === '0, "R1", out_result, 64'd0);

        // directed corners
        run_op(4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);   // R4 carry kept
        run_op(4'd0, 64'h0001_0203_8000_FF10, 64'h0000_0102_0080_00F0);   // R4 round up
        run_op(4'd1, 64'hFFFF_0001_8000_0000, 64'hFFFF_0000_8000_0001);   // R5
        run_op(4'd2, 64'hFFFF_FFFF_8000_0001, 64'hFFFF_0002_8000_FFFF);   // R6
        run_op(4'd3, 64'h8000_7FFF_FFFF_0001, 64'h7FFF_8000_0001_FFFF);   // R7 signed max
        run_op(4'd4, 64'h8000_7FFF_FFFF_0001, 64'h7FFF_8000_0001_FFFF);   // R7 signed min
        run_op(4'd5, 64'h80FF_0001_7F00_FF01, 64'h7F00_FF00_8001_01FF);   // R8 unsigned max
        run_op(4'd6, 64'h80FF_0001_7F00_FF01, 64'h7F00_FF00_8001_01FF);   // R8 unsigned min
        run_op(4'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000);   // R9 max 2040
        run_op(4'd7, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0);   // R9 zero
        run_op(4'd8, 64'h80_7F_FF_00_81_01_C0_40, 64'hFFFF_FFFF_FFFF_FFFF); // R10
        run_op(4'd9, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);                      // R11
        run_op(4'd15, 64'h1234, 64'h5678);                                 // R11

        // back-to-back: R2 valid stays high across consecutive requests
        @(negedge clk);
        in_valid = 1'b1; in_op = 4'd0; in_a = 64'h10; in_b = 64'h20;
        @(negedge clk);
        in_op = 4'd7; in_a = 64'h0; in_b = 64'h0505;
        check(out_valid === 1'b1 && out_result === 64'h18, "R2", out_result, 64'h18);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid === 1'b1 && out_result === 64'd10, "R9", out_result, 64'd10);
        @(negedge clk);

        // constrained random
        for (int k = 0; k < 400; k++) begin
            logic [3:0] op = (($urandom % 8) == 0) ? 4'(9 + $urandom % 7) : 4'($urandom % 9);
            run_op(op, {$urandom, $urandom}, {$urandom, $urandom});
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule